// File: doc/BRIEF.md
# Boot-Mode Flash Address Remapper

This block sits between the processor bus and the on-chip code storage. Each cycle it may receive one system-space access. One cycle later it returns the matching physical address and a one-hot region select. The regions are the application area, the loader area, the data area and SRAM. The data area is the top part of the application area, from a configurable base upward. A two-bit boot-selection field sets the translation. Bit 1 names the booted area, and bit 0 switches run-time programming visibility on or off.

When visibility is off, only the booted flash area answers, and it answers at address zero. SRAM stays visible in every mode. When visibility is on, both flash areas answer at their own addresses. In that mode the first 512 bytes of system space form a vector window. A remap command can point this window at the application area, the loader area or SRAM.

The block also reports writes that reach the application area while its unlock input is low. Writes to the data area never need the unlock. Addresses that match no window are flagged as invalid.

Top module: `boot_remap`

## Requirements
- R1: A synchronous active-high reset clears rsp_valid, rsp_region, rsp_invalid, rsp_wr_deny and remap_err. It loads vec_sel with the booted area: 0 (application) when boot_sel[1]=0, and 1 (loader) when boot_sel[1]=1.
- R2: All response outputs are registered and appear one cycle after the request. A cycle without req_valid gives rsp_valid=0 and all-zero rsp_faddr, rsp_region, rsp_invalid and rsp_wr_deny.
- R3: With boot_sel=2'b00 (application boot, programming visibility off), addresses below APP_SIZE pass through unchanged. rsp_region bit 0 (application) or bit 2 (data) is set. Loader-space addresses are invalid in this mode.
- R4: With boot_sel=2'b10 (loader boot, visibility off), an address A below LDR_SIZE becomes LDR_BASE+A with rsp_region bit 1 (loader) set. A=LDR_SIZE and above, and the loader's own base address, are invalid.
- R5: With boot_sel[0]=1, application addresses outside the vector window pass through unchanged. Addresses from LDR_BASE to LDR_BASE+LDR_SIZE-1 pass through unchanged with bit 1 set.
- R6: An application-area address at or above df_base sets bit 2 (data) instead of bit 0. The address equal to df_base is data, and df_base-1 is application.
- R7: With boot_sel[0]=1, an address A below VEC_BYTES=512 follows vec_sel. Code 0 gives A with bit 0 set. Code 1 gives LDR_BASE+A with bit 1 set. Code 2 gives SRAM_BASE+A with bit 3 set. Address VEC_BYTES is outside the window.
- R8: When boot_sel[0]=1, a remap command with code 0, 1 or 2 loads vec_sel at the next edge. An access in the same cycle as the command still uses the old vec_sel. The next access uses the new one.
- R9: A remap command is rejected when boot_sel[0]=0 or when its code is 3. A rejected command leaves vec_sel unchanged and raises remap_err for exactly one cycle, in the cycle after the command.
- R10: An address outside every visible window gives rsp_invalid=1, rsp_region=0 and rsp_faddr=0. rsp_region never has more than one bit set.
- R11: A write (req_wr=1) that resolves to the application region while app_unlock=0 raises rsp_wr_deny. Writes to the data, loader or SRAM regions never raise it. With app_unlock=1 it stays low.
- R12: The SRAM window, from SRAM_BASE to SRAM_BASE+SRAM_SIZE-1, is visible in every boot mode with an unchanged address and bit 3 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_sel | input | 2 | Boot selection: bit 1 selects the booted area (1 = loader), bit 0 turns programming visibility on |
| df_base | input | AW | Start of the data area in application space |
| req_valid | input | 1 | Access request present |
| req_addr | input | AW | System-space address |
| req_wr | input | 1 | Access is a write |
| app_unlock | input | 1 | Application-area write unlock |
| remap_valid | input | 1 | Vector remap command |
| remap_sel | input | 2 | Remap target: 0 application, 1 loader, 2 SRAM, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_faddr | output | AW | Translated physical address |
| rsp_region | output | 4 | One-hot region: bit 0 application, 1 loader, 2 data, 3 SRAM |
| rsp_invalid | output | 1 | Address matched no visible window |
| rsp_wr_deny | output | 1 | Write to a locked application area |
| remap_err | output | 1 | One-cycle pulse for a rejected remap command |
| vec_sel | output | 2 | Current vector-window target |

## Verification
An access that hits the vector window can arrive in the same cycle as a remap command. The bench provokes this by driving both in one step, first with a code that is accepted and then with codes that are rejected. The same-cycle access must come back translated with the previous target. The following access to the same address must use the new target, and vec_sel must show the new value. After a rejected command, the access must come back unchanged, remap_err must pulse and vec_sel must keep its value.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int RG_N    = 4;
  localparam int RG_APP  = 0;
  localparam int RG_LDR  = 1;
  localparam int RG_DATA = 2;
  localparam int RG_SRAM = 3;

  typedef logic [RG_N-1:0] region_t;

  localparam logic [1:0] VS_APP  = 2'd0;
  localparam logic [1:0] VS_LDR  = 2'd1;
  localparam logic [1:0] VS_SRAM = 2'd2;
  localparam logic [1:0] VS_RSV  = 2'd3;

  function automatic region_t region_bit(input int idx);
    region_t r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/remap_window.sv
module remap_window #(
  parameter int             AW   = 32,
  parameter logic [AW-1:0]  BASE = '0,
  parameter logic [AW-1:0]  SIZE = 32'h0000_1000
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [AW-1:0] offset;
  // The subtraction wraps for addresses below BASE, so one compare suffices.
  assign offset = addr - BASE;
  assign hit    = offset < SIZE;
endmodule

// File: rtl/remap_vec_reg.sv
module remap_vec_reg
  import remap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       boot_ldr,
  input  logic       iap_on,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_sel,
  output logic [1:0] vsel,
  output logic       err
);
  logic accept;
  assign accept = iap_on && (cmd_sel != VS_RSV);

  always_ff @(posedge clk) begin
    if (rst) begin
      vsel <= boot_ldr ? VS_LDR : VS_APP;
      err  <= 1'b0;
    end else begin
      err <= 1'b0;
      if (cmd_valid) begin
        if (accept) vsel <= cmd_sel;
        else        err  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/remap_decode.sv
module remap_decode
  import remap_pkg::*;
#(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] APP_SIZE  = 32'h0002_0000,
  parameter logic [AW-1:0] LDR_BASE  = 32'h0010_0000,
  parameter logic [AW-1:0] LDR_SIZE  = 32'h0000_1000,
  parameter logic [AW-1:0] SRAM_BASE = 32'h2000_0000,
  parameter logic [AW-1:0] SRAM_SIZE = 32'h0000_4000,
  parameter logic [AW-1:0] VEC_BYTES = 32'h0000_0200
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] df_base,
  input  logic          iap_on,
  input  logic          boot_ldr,
  input  logic [1:0]    vsel,
  input  logic          wr,
  input  logic          unlock,
  output logic [AW-1:0] faddr,
  output region_t       region,
  output logic          invalid,
  output logic          wr_deny
);
  localparam int NW = 5;
  localparam int W_VEC = 0, W_APP = 1, W_LDR = 2, W_LDR0 = 3, W_SRAM = 4;
  localparam logic [AW-1:0] WBASE [NW] = '{'0, '0, LDR_BASE, '0, SRAM_BASE};
  localparam logic [AW-1:0] WSIZE [NW] = '{VEC_BYTES, APP_SIZE, LDR_SIZE, LDR_SIZE, SRAM_SIZE};

  logic [NW-1:0] hit;

  for (genvar i = 0; i < NW; i++) begin : g_win
    remap_window #(.AW(AW), .BASE(WBASE[i]), .SIZE(WSIZE[i])) u_win (
      .addr (addr),
      .hit  (hit[i])
    );
  end

  logic in_data;
  assign in_data = addr >= df_base;

  always_comb begin
    faddr   = '0;
    region  = '0;
    invalid = 1'b0;
    if (iap_on) begin
      if (hit[W_VEC]) begin
        unique case (vsel)
          VS_APP:  begin faddr = addr;             region = region_bit(RG_APP);  end
          VS_LDR:  begin faddr = LDR_BASE + addr;  region = region_bit(RG_LDR);  end
          VS_SRAM: begin faddr = SRAM_BASE + addr; region = region_bit(RG_SRAM); end
          default: invalid = 1'b1;
        endcase
      end else if (hit[W_APP]) begin
        faddr  = addr;
        region = in_data ? region_bit(RG_DATA) : region_bit(RG_APP);
      end else if (hit[W_LDR]) begin
        faddr  = addr;
        region = region_bit(RG_LDR);
      end else if (hit[W_SRAM]) begin
        faddr  = addr;
        region = region_bit(RG_SRAM);
      end else begin
        invalid = 1'b1;
      end
    end else begin
      if (!boot_ldr && hit[W_APP]) begin
        faddr  = addr;
        region = in_data ? region_bit(RG_DATA) : region_bit(RG_APP);
      end else if (boot_ldr && hit[W_LDR0]) begin
        faddr  = LDR_BASE + addr;
        region = region_bit(RG_LDR);
      end else if (hit[W_SRAM]) begin
        faddr  = addr;
        region = region_bit(RG_SRAM);
      end else begin
        invalid = 1'b1;
      end
    end
  end

  assign wr_deny = wr && region[RG_APP] && !unlock;
endmodule

// File: rtl/boot_remap.sv
module boot_remap
  import remap_pkg::*;
#(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] APP_SIZE  = 32'h0002_0000,
  parameter logic [AW-1:0] LDR_BASE  = 32'h0010_0000,
  parameter logic [AW-1:0] LDR_SIZE  = 32'h0000_1000,
  parameter logic [AW-1:0] SRAM_BASE = 32'h2000_0000,
  parameter logic [AW-1:0] SRAM_SIZE = 32'h0000_4000,
  parameter logic [AW-1:0] VEC_BYTES = 32'h0000_0200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    boot_sel,
  input  logic [AW-1:0] df_base,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic          app_unlock,
  input  logic          remap_valid,
  input  logic [1:0]    remap_sel,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_faddr,
  output logic [3:0]    rsp_region,
  output logic          rsp_invalid,
  output logic          rsp_wr_deny,
  output logic          remap_err,
  output logic [1:0]    vec_sel
);
  logic          iap_on, boot_ldr;
  logic [AW-1:0] d_faddr;
  region_t       d_region;
  logic          d_invalid, d_deny;

  assign iap_on   = boot_sel[0];
  assign boot_ldr = boot_sel[1];

  remap_vec_reg u_vec (
    .clk       (clk),
    .rst       (rst),
    .boot_ldr  (boot_ldr),
    .iap_on    (iap_on),
    .cmd_valid (remap_valid),
    .cmd_sel   (remap_sel),
    .vsel      (vec_sel),
    .err       (remap_err)
  );

  remap_decode #(
    .AW(AW), .APP_SIZE(APP_SIZE), .LDR_BASE(LDR_BASE), .LDR_SIZE(LDR_SIZE),
    .SRAM_BASE(SRAM_BASE), .SRAM_SIZE(SRAM_SIZE), .VEC_BYTES(VEC_BYTES)
  ) u_dec (
    .addr     (req_addr),
    .df_base  (df_base),
    .iap_on   (iap_on),
    .boot_ldr (boot_ldr),
    .vsel     (vec_sel),
    .wr       (req_wr),
    .unlock   (app_unlock),
    .faddr    (d_faddr),
    .region   (d_region),
    .invalid  (d_invalid),
    .wr_deny  (d_deny)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid   <= 1'b0;
      rsp_faddr   <= '0;
      rsp_region  <= '0;
      rsp_invalid <= 1'b0;
      rsp_wr_deny <= 1'b0;
    end else begin
      rsp_valid   <= 1'b1;
      rsp_faddr   <= d_faddr;
      rsp_region  <= d_region;
      rsp_invalid <= d_invalid;
      rsp_wr_deny <= d_deny;
    end
  end
endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] boot_sel,
  input logic       req_valid,
  input logic       remap_valid,
  input logic [1:0] remap_sel,
  input logic       rsp_valid,
  input logic [3:0] rsp_region,
  input logic       rsp_invalid,
  input logic       rsp_wr_deny,
  input logic       remap_err,
  input logic [1:0] vec_sel
);
  // R2
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid == $past(req_valid)));

  // R10
  region_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_region));

  // R10
  invalid_noregion_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_invalid |-> (rsp_region == 4'b0000));

  // R11
  deny_app_only_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_wr_deny |-> rsp_region[0]);

  // R8
  remap_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (remap_valid && boot_sel[0] && remap_sel != 2'd3) |=> (vec_sel == $past(remap_sel)) && !remap_err);

  // R9
  remap_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (remap_valid && (!boot_sel[0] || remap_sel == 2'd3)) |=> remap_err && $stable(vec_sel));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!remap_valid) |=> !remap_err);
endmodule

bind boot_remap boot_remap_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .boot_sel    (boot_sel),
  .req_valid   (req_valid),
  .remap_valid (remap_valid),
  .remap_sel   (remap_sel),
  .rsp_valid   (rsp_valid),
  .rsp_region  (rsp_region),
  .rsp_invalid (rsp_invalid),
  .rsp_wr_deny (rsp_wr_deny),
  .remap_err   (remap_err),
  .vec_sel     (vec_sel)
);

// File: tb/sim_boot_remap.sv
`timescale 1ns/1ps
module sim_boot_remap;
  localparam logic [31:0] APP_SIZE  = 32'h0002_0000;
  localparam logic [31:0] LDR_BASE  = 32'h0010_0000;
  localparam logic [31:0] LDR_SIZE  = 32'h0000_1000;
  localparam logic [31:0] SRAM_BASE = 32'h2000_0000;
  localparam logic [31:0] SRAM_SIZE = 32'h0000_4000;
  localparam logic [31:0] VEC_BYTES = 32'h0000_0200;
  localparam logic [31:0] DFB       = 32'h0001_F000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  boot_sel = 2'b00;
  logic [31:0] df_base = DFB;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic        app_unlock = 1'b0;
  logic        remap_valid = 1'b0;
  logic [1:0]  remap_sel = 2'd0;
  logic        rsp_valid, rsp_invalid, rsp_wr_deny, remap_err;
  logic [31:0] rsp_faddr;
  logic [3:0]  rsp_region;
  logic [1:0]  vec_sel;

  always #4 clk = ~clk;

  boot_remap u0 (
    .clk(clk), .rst(rst), .boot_sel(boot_sel), .df_base(df_base),
    .req_valid(req_valid), .req_addr(req_addr), .req_wr(req_wr),
    .app_unlock(app_unlock), .remap_valid(remap_valid), .remap_sel(remap_sel),
    .rsp_valid(rsp_valid), .rsp_faddr(rsp_faddr), .rsp_region(rsp_region),
    .rsp_invalid(rsp_invalid), .rsp_wr_deny(rsp_wr_deny),
    .remap_err(remap_err), .vec_sel(vec_sel)
  );

  typedef struct {
    logic        v;
    logic [31:0] fa;
    logic [3:0]  rg;
    logic        inv;
    logic        den;
    logic        err;
    logic [1:0]  vs;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  logic [1:0]  m_vs;
  bit          done = 0;

  function automatic bit in_win(logic [31:0] a, logic [31:0] b, logic [31:0] s);
    return (a >= b) && (a < b + s);
  endfunction

  // Expected translation, built from the requirement text.
  function automatic exp_t model(logic v, logic [31:0] a, logic w, logic ul,
                                 logic [1:0] bs, logic [1:0] vs);
    exp_t e;
    e.v = v; e.fa = '0; e.rg = '0; e.inv = 0; e.den = 0; e.err = 0; e.vs = vs; e.tag = "";
    if (!v) return e;
    if (bs[0]) begin
      if (a < VEC_BYTES) begin
        if (vs == 2'd0)      begin e.fa = a;             e.rg = 4'b0001; end
        else if (vs == 2'd1) begin e.fa = LDR_BASE + a;  e.rg = 4'b0010; end
        else                 begin e.fa = SRAM_BASE + a; e.rg = 4'b1000; end
      end else if (a < APP_SIZE) begin
        e.fa = a; e.rg = (a >= DFB) ? 4'b0100 : 4'b0001;
      end else if (in_win(a, LDR_BASE, LDR_SIZE)) begin
        e.fa = a; e.rg = 4'b0010;
      end else if (in_win(a, SRAM_BASE, SRAM_SIZE)) begin
        e.fa = a; e.rg = 4'b1000;
      end else e.inv = 1;
    end else begin
      if (!bs[1] && a < APP_SIZE) begin
        e.fa = a; e.rg = (a >= DFB) ? 4'b0100 : 4'b0001;
      end else if (bs[1] && a < LDR_SIZE) begin
        e.fa = LDR_BASE + a; e.rg = 4'b0010;
      end else if (in_win(a, SRAM_BASE, SRAM_SIZE)) begin
        e.fa = a; e.rg = 4'b1000;
      end else e.inv = 1;
    end
    e.den = w && e.rg[0] && !ul;
    return e;
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic w, input logic ul,
                      input logic rv, input logic [1:0] rs, input string tag);
    exp_t e;
    logic [1:0] nvs;
    bit rej;
    @(negedge clk);
    req_valid = v; req_addr = a; req_wr = w; app_unlock = ul;
    remap_valid = rv; remap_sel = rs;
    rej = rv && (!boot_sel[0] || rs == 2'd3);
    nvs = (rv && !rej) ? rs : m_vs;
    e = model(v, a, w, ul, boot_sel, m_vs);
    e.err = rej;
    e.vs  = nvs;
    e.tag = tag;
    q.push_back(e);
    m_vs = nvs;
  endtask

  task automatic do_reset(input logic [1:0] bs);
    @(negedge clk);
    rst = 1; boot_sel = bs;
    req_valid = 0; remap_valid = 0; req_wr = 0; app_unlock = 0;
    @(negedge clk);
    @(negedge clk);
    m_vs = bs[1] ? 2'd1 : 2'd0;
    checks++;
    if (rsp_valid !== 0 || rsp_region !== 0 || rsp_invalid !== 0 || rsp_wr_deny !== 0 ||
        remap_err !== 0 || vec_sel !== m_vs) begin
      errors++;
      $display("FAIL R1 reset: valid=%b region=%b inv=%b deny=%b err=%b vsel=%0d expected zeros vsel=%0d",
               rsp_valid, rsp_region, rsp_invalid, rsp_wr_deny, remap_err, vec_sel, m_vs);
    end
    rst = 0;
  endtask

  // Monitor: pops one expected item per cycle, mid-way before the next drive.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rsp_valid !== e.v || rsp_faddr !== e.fa || rsp_region !== e.rg ||
          rsp_invalid !== e.inv || rsp_wr_deny !== e.den || remap_err !== e.err ||
          vec_sel !== e.vs) begin
        errors++;
        $display("FAIL %s: got v=%b fa=%h rg=%b inv=%b den=%b err=%b vs=%0d expected v=%b fa=%h rg=%b inv=%b den=%b err=%b vs=%0d",
                 e.tag, rsp_valid, rsp_faddr, rsp_region, rsp_invalid, rsp_wr_deny, remap_err, vec_sel,
                 e.v, e.fa, e.rg, e.inv, e.den, e.err, e.vs);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_vs = 2'd0;
    // Application boot, visibility off
    do_reset(2'b00);
    step(1, 32'h0000_0100, 0, 0, 0, 0, "R3 app pass");
    step(1, 32'h0001_F010, 0, 0, 0, 0, "R6 data in app boot");
    step(1, LDR_BASE,      0, 0, 0, 0, "R3 loader hidden");
    step(1, 32'h2000_0010, 0, 0, 0, 0, "R12 sram app boot");
    step(1, 32'h0000_0400, 1, 0, 0, 0, "R11 locked app write");
    step(1, 32'h0001_F020, 1, 0, 0, 0, "R11 data write free");
    step(1, 32'h0000_0400, 1, 1, 0, 0, "R11 unlocked app write");
    step(1, 32'h0000_0010, 0, 0, 1, 2'd1, "R9 remap without visibility");
    step(1, 32'h0000_0010, 0, 0, 0, 0, "R9 vector unchanged");
    step(0, 32'h0000_0010, 0, 0, 0, 0, "R2 idle zeros");
    step(1, 32'h0003_0000, 0, 0, 0, 0, "R10 outside");
    step(0, 0, 0, 0, 0, 0, "R2 drain");
    // Loader boot, visibility off
    do_reset(2'b10);
    step(1, 32'h0000_0020, 0, 0, 0, 0, "R4 loader at zero");
    step(1, 32'h0000_0FFF, 1, 0, 0, 0, "R4 loader top");
    step(1, 32'h0000_1000, 0, 0, 0, 0, "R4 past loader");
    step(1, LDR_BASE,      0, 0, 0, 0, "R4 loader base hidden");
    step(1, 32'h2000_3FFF, 0, 0, 0, 0, "R12 sram top loader boot");
    step(1, 32'h2000_4000, 0, 0, 0, 0, "R10 past sram");
    step(0, 0, 0, 0, 0, 0, "R2 drain");
    // Application boot, visibility on
    do_reset(2'b01);
    step(1, 32'h0000_0080, 0, 0, 0, 0, "R7 window to app");
    step(1, 32'h0010_0010, 0, 0, 0, 0, "R5 loader identity");
    step(1, 32'h0000_5000, 1, 0, 0, 0, "R5 app identity locked write");
    step(1, DFB,           0, 0, 0, 0, "R6 data boundary");
    step(1, DFB - 1,       0, 0, 0, 0, "R6 app below boundary");
    step(1, 32'h0000_0080, 0, 0, 1, 2'd1, "R8 same-cycle remap uses old");
    step(1, 32'h0000_0080, 0, 0, 0, 0, "R8 next access uses loader");
    step(1, 32'h0000_01FF, 1, 0, 0, 0, "R7 window top to loader");
    step(1, 32'h0000_0200, 0, 0, 0, 0, "R7 past window");
    step(0, 0, 0, 0, 1, 2'd2, "R8 remap to sram");
    step(1, 32'h0000_0040, 1, 0, 0, 0, "R7 window to sram");
    step(1, 32'h0000_0040, 0, 0, 1, 2'd3, "R9 reserved code");
    step(1, 32'h0000_0044, 0, 0, 0, 0, "R9 target kept");
    step(1, 32'h0010_1000, 0, 0, 0, 0, "R10 past loader");
    step(0, 0, 0, 0, 0, 0, "R2 drain");
    // Loader boot, visibility on
    do_reset(2'b11);
    step(1, 32'h0000_0004, 0, 0, 0, 0, "R7 window to loader after reset");
    step(1, 32'h0010_0004, 0, 0, 0, 0, "R5 loader identity");
    step(1, 32'h0000_8000, 0, 0, 0, 0, "R5 app visible");
    step(1, 32'h0000_0004, 0, 0, 1, 2'd0, "R8 remap to app same cycle");
    step(1, 32'h0000_0004, 1, 0, 0, 0, "R8 app via window");
    step(0, 0, 0, 0, 0, 0, "R2 drain");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule